// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block is the interlock for an in-order, five-stage instruction pipeline (fetch, decode, execute, memory, writeback) in which every stage takes one clock. Each cycle it sees the instruction currently in decode: its source register numbers with per-source read flags, its destination register with a write flag, and a flag saying whether it will use the shared memory port. It keeps its own shadow record of the three instructions ahead of decode. The record advances with the stall decisions the block itself makes, so the controller always knows which registers are still waiting to be written and when a data access holds the single memory port.

The block handles two hazards. The first is a read-after-write dependency when there is no forwarding path. A result reaches the register file only in writeback, and that file writes before it reads within a cycle. A consumer in decode must therefore wait while its producer is in execute or memory. It holds decode and fetch and puts a bubble into execute. The second is a structural conflict. While a data access occupies the memory port, fetch cannot run. Fetch holds its address and a bubble enters decode, while the decode instruction still moves forward. When both hazards occur in the same cycle, the data stall takes over: fetch and decode both hold and execute gets the bubble.

The per-cycle decision is one of four named actions. FLOW means no hazard. RAW_STALL means a data hazard only. PORT_IDLE means a memory-port conflict only. BOTH_STALL means both at once. The block moves between them each cycle purely from the hazard inputs. FLOW goes to RAW_STALL when a dependency appears, to PORT_IDLE when a memory access reaches the memory stage, and to BOTH_STALL when the two coincide. Any action returns to FLOW once its hazards clear.

Top module: `hz_stall_ctrl`

## Requirements
- R1: Straight after reset the shadow stages are empty, so stall, if_hold, id_hold, ex_bubble and id_bubble are all 0 even when decode presents a valid instruction that reads a nonzero register.
- R2: If a valid decode instruction reads (flag set) a nonzero register that the instruction in execute or in memory will write, then stall, if_hold, id_hold and ex_bubble are 1 in that cycle.
- R3: A consumer directly behind its producer is held for exactly two cycles and then proceeds.
- R4: A consumer with one unrelated instruction between it and its producer is held for exactly one cycle.
- R5: A consumer with two or more instructions between it and its producer is not held, because the register file writes before it reads in the same cycle.
- R6: Register 0 never creates a dependency, even when an in-flight instruction names it as its destination.
- R7: A source register whose read flag is clear is ignored in the dependency check.
- R8: An in-flight instruction whose write flag is clear, or a bubble, never causes a dependency.
- R9: In a cycle when the memory stage holds a valid instruction with its memory flag set and there is no data hazard, if_hold and id_bubble are 1 while stall, id_hold and ex_bubble are 0.
- R10: When a data hazard and a memory-port conflict occur in the same cycle, stall, if_hold, id_hold and ex_bubble are 1 and id_bubble is 0.
- R11: An instruction held in decode is tracked only once. A memory instruction that was stalled occupies the port for exactly one cycle, and the bubble put into execute is recorded as empty.
- R12: While id_valid is 0, no data stall is raised, whatever the register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the shadow stages |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | 5 | First source register number |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | 5 | Second source register number |
| id_rs2_en | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register number |
| id_rd_wr | input | 1 | Instruction writes its destination |
| id_mem | input | 1 | Instruction uses the memory port in the memory stage |
| stall | output | 1 | Data hazard present this cycle |
| if_hold | output | 1 | Fetch keeps its address and does not access memory |
| id_hold | output | 1 | Decode keeps its instruction |
| ex_bubble | output | 1 | Execute receives an empty slot instead of the decode instruction |
| id_bubble | output | 1 | Decode receives an empty slot because fetch idled |

## Verification
The assertions assume the surrounding pipeline obeys the hold outputs. While id_hold is 1, the same instruction stays in decode. After an id_bubble cycle, decode is empty. If a different instruction slipped into a held decode slot, the bound on consecutive stalls would no longer hold. The bench meets this by modelling the front of the pipeline itself: each cycle it keeps, empties or advances its decode instruction according to the expected hold and bubble values. Random programs use only registers 0 to 3 and a high share of memory instructions, so dependencies, register-0 cases and port conflicts are frequent, and directed programs set exact producer–consumer distances.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Shadow stage positions behind decode
    localparam int unsigned STG_EX    = 0;
    localparam int unsigned STG_MEM   = 1;
    localparam int unsigned STG_WB    = 2;
    localparam int unsigned TRK_DEPTH = 3;
    // Producers that still block a reader: every tracked stage but the last,
    // since the last stage writes before the register file is read.
    localparam int unsigned RAW_SPAN  = TRK_DEPTH - 1;
    localparam int unsigned NUM_SRC   = 2;

    typedef enum logic [1:0] {
        ACT_FLOW       = 2'd0,
        ACT_RAW_STALL  = 2'd1,
        ACT_PORT_IDLE  = 2'd2,
        ACT_BOTH_STALL = 2'd3
    } hz_action_e;

endpackage

// File: rtl/hz_track.sv
module hz_track #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic                         in_wr,
    input  logic                         in_mem,
    input  logic [REG_W-1:0]             in_rd,
    output logic [DEPTH-1:0]             vld,
    output logic [DEPTH-1:0]             wr,
    output logic [DEPTH-1:0]             mem,
    output logic [DEPTH-1:0][REG_W-1:0]  rd
);

    // Shadow of the stages after decode; slot 0 is execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            wr  <= '0;
            mem <= '0;
            rd  <= '0;
        end else begin
            vld[0] <= in_vld;
            wr[0]  <= in_vld & in_wr;
            mem[0] <= in_vld & in_mem;
            rd[0]  <= in_rd;
            for (int k = 1; k < DEPTH; k++) begin
                vld[k] <= vld[k-1];
                wr[k]  <= wr[k-1];
                mem[k] <= mem[k-1];
                rd[k]  <= rd[k-1];
            end
        end
    end

endmodule

// File: rtl/hz_raw_cmp.sv
module hz_raw_cmp #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSRC  = 2,
    parameter int unsigned NCHK  = 2
) (
    input  logic                        cons_vld,
    input  logic [NSRC-1:0]             src_use,
    input  logic [NSRC-1:0][REG_W-1:0]  src_reg,
    input  logic [NCHK-1:0]             prod_vld,
    input  logic [NCHK-1:0]             prod_wr,
    input  logic [NCHK-1:0][REG_W-1:0]  prod_rd,
    output logic [NSRC-1:0]             src_hit,
    output logic                        any_hit
);

    logic [NCHK-1:0] match [NSRC];

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar p = 0; p < NCHK; p++) begin : g_prod
            assign match[s][p] = prod_vld[p] && prod_wr[p] &&
                                 (prod_rd[p] == src_reg[s]);
        end
        assign src_hit[s] = cons_vld && src_use[s] &&
                            (src_reg[s] != '0) && (|match[s]);
    end

    assign any_hit = |src_hit;

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic        raw_hit,
    input  logic        port_busy,
    output hz_action_e  action,
    output logic        stall,
    output logic        if_hold,
    output logic        id_hold,
    output logic        ex_bubble,
    output logic        id_bubble
);

    always_comb begin
        unique case ({raw_hit, port_busy})
            2'b00:   action = ACT_FLOW;
            2'b10:   action = ACT_RAW_STALL;
            2'b01:   action = ACT_PORT_IDLE;
            default: action = ACT_BOTH_STALL;
        endcase
    end

    always_comb begin
        stall     = 1'b0;
        if_hold   = 1'b0;
        id_hold   = 1'b0;
        ex_bubble = 1'b0;
        id_bubble = 1'b0;
        unique case (action)
            ACT_FLOW: ;
            ACT_RAW_STALL, ACT_BOTH_STALL: begin
                stall     = 1'b1;
                if_hold   = 1'b1;
                id_hold   = 1'b1;
                ex_bubble = 1'b1;
            end
            ACT_PORT_IDLE: begin
                if_hold   = 1'b1;
                id_bubble = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_rs1,
    input  logic             id_rs1_en,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs2_en,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_rd_wr,
    input  logic             id_mem,
    output logic             stall,
    output logic             if_hold,
    output logic             id_hold,
    output logic             ex_bubble,
    output logic             id_bubble
);

    logic [TRK_DEPTH-1:0]            trk_vld;
    logic [TRK_DEPTH-1:0]            trk_wr;
    logic [TRK_DEPTH-1:0]            trk_mem;
    logic [TRK_DEPTH-1:0][REG_W-1:0] trk_rd;
    logic [NUM_SRC-1:0]              src_hit;
    logic                            raw_hit;
    logic                            port_busy;
    hz_action_e                      action;

    hz_track #(.REG_W(REG_W), .DEPTH(TRK_DEPTH)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (id_valid & ~ex_bubble),
        .in_wr  (id_rd_wr),
        .in_mem (id_mem),
        .in_rd  (id_rd),
        .vld    (trk_vld),
        .wr     (trk_wr),
        .mem    (trk_mem),
        .rd     (trk_rd)
    );

    hz_raw_cmp #(.REG_W(REG_W), .NSRC(NUM_SRC), .NCHK(RAW_SPAN)) u_raw (
        .cons_vld (id_valid),
        .src_use  ({id_rs2_en, id_rs1_en}),
        .src_reg  ({id_rs2, id_rs1}),
        .prod_vld (trk_vld[RAW_SPAN-1:0]),
        .prod_wr  (trk_wr[RAW_SPAN-1:0]),
        .prod_rd  (trk_rd[RAW_SPAN-1:0]),
        .src_hit  (src_hit),
        .any_hit  (raw_hit)
    );

    assign port_busy = trk_vld[STG_MEM] & trk_mem[STG_MEM];

    hz_ctrl u_ctrl (
        .raw_hit   (raw_hit),
        .port_busy (port_busy),
        .action    (action),
        .stall     (stall),
        .if_hold   (if_hold),
        .id_hold   (id_hold),
        .ex_bubble (ex_bubble),
        .id_bubble (id_bubble)
    );

endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk (
    input logic clk,
    input logic rst_n,
    input logic id_valid,
    input logic stall,
    input logic if_hold,
    input logic id_hold,
    input logic ex_bubble,
    input logic id_bubble,
    input logic ex_vld,
    input logic mem_busy
);

    p_raw_holds_front_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (if_hold && id_hold && ex_bubble));

    p_stall_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |=> !stall);

    p_port_idles_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |-> if_hold);

    p_no_hold_and_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        id_bubble |-> !id_hold);

    p_bubble_tracked_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> !ex_vld);

    p_stall_needs_decode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> id_valid);

endmodule

bind hz_stall_ctrl hz_stall_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .stall     (stall),
    .if_hold   (if_hold),
    .id_hold   (id_hold),
    .ex_bubble (ex_bubble),
    .id_bubble (id_bubble),
    .ex_vld    (trk_vld[hz_pkg::STG_EX]),
    .mem_busy  (port_busy)
);

// File: tb/hz_stall_ctrl_tb.sv
module hz_stall_ctrl_tb;

    typedef struct packed {
        logic       v;
        logic [4:0] rs1;
        logic       u1;
        logic [4:0] rs2;
        logic       u2;
        logic [4:0] rd;
        logic       w;
        logic       m;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid, id_rs1_en, id_rs2_en, id_rd_wr, id_mem;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic stall, if_hold, id_hold, ex_bubble, id_bubble;

    always #10 clk = ~clk;

    hz_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_en(id_rs1_en),
        .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
        .id_rd(id_rd), .id_rd_wr(id_rd_wr), .id_mem(id_mem),
        .stall(stall), .if_hold(if_hold), .id_hold(id_hold),
        .ex_bubble(ex_bubble), .id_bubble(id_bubble)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    ins_t m_ex, m_mem, cur;
    ins_t prog [16];
    int   plen, pidx;
    int   c_stall, c_port, c_both;

    function automatic ins_t mk(logic v, logic [4:0] rs1, logic u1,
                                logic [4:0] rs2, logic u2,
                                logic [4:0] rd, logic w, logic m);
        ins_t t;
        t.v = v; t.rs1 = rs1; t.u1 = u1; t.rs2 = rs2; t.u2 = u2;
        t.rd = rd; t.w = w; t.m = m;
        return t;
    endfunction

    function automatic logic hit(ins_t p, logic [4:0] r);
        return p.v && p.w && (p.rd == r);
    endfunction

    function automatic logic exp_raw(ins_t i, ins_t e, ins_t mm);
        logic a, b;
        a = i.u1 && (i.rs1 != 0) && (hit(e, i.rs1) || hit(mm, i.rs1));
        b = i.u2 && (i.rs2 != 0) && (hit(e, i.rs2) || hit(mm, i.rs2));
        return i.v && (a || b);
    endfunction

    task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic chk_int(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic drive(ins_t t);
        id_valid = t.v; id_rs1 = t.rs1; id_rs1_en = t.u1;
        id_rs2 = t.rs2; id_rs2_en = t.u2;
        id_rd = t.rd; id_rd_wr = t.w; id_mem = t.m;
    endtask

    // One pipeline cycle: drive decode, compare outputs, advance the model.
    task automatic one_cycle();
        logic er, ep;
        logic [4:0] ex;
        string tag;
        @(negedge clk);
        drive(cur);
        #2;
        er = exp_raw(cur, m_ex, m_mem);
        ep = m_mem.v && m_mem.m;
        // bit order: stall, if_hold, id_hold, ex_bubble, id_bubble
        ex = {er, er | ep, er, er, ep & ~er};
        if (er && ep)  tag = "R10 both hazards";
        else if (er)   tag = "R2 data hazard";
        else if (ep)   tag = "R9 port conflict";
        else           tag = "R5 free flow";
        chk(tag, {stall, if_hold, id_hold, ex_bubble, id_bubble}, ex);
        c_stall += int'(er);
        c_port  += int'(ep);
        c_both  += int'(er && ep);
        @(posedge clk);
        m_mem = m_ex;
        m_ex  = er ? '0 : cur;
        if (!er) begin
            if (ep)              cur = '0;
            else if (pidx < plen) begin cur = prog[pidx]; pidx++; end
            else                 cur = '0;
        end
    endtask

    task automatic run_prog();
        int guard;
        c_stall = 0; c_port = 0; c_both = 0;
        cur = prog[0]; pidx = 1; guard = 0;
        while ((cur.v || pidx < plen || m_ex.v || m_mem.v) && guard < 100) begin
            one_cycle();
            guard++;
        end
        one_cycle();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        m_ex = '0; m_mem = '0; cur = '0;
        drive(mk(1, 5'd1, 1, 5'd2, 1, 5'd3, 1, 1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 reset state", {stall, if_hold, id_hold, ex_bubble, id_bubble}, 5'b0);
        @(posedge clk);
        // the reset-check instruction entered execute; let it drain
        m_ex = mk(1, 5'd1, 1, 5'd2, 1, 5'd3, 1, 1);
        plen = 1; prog[0] = '0;
        run_prog();

        // R3: back-to-back dependence
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0);
        prog[1] = mk(1, 5'd5, 1, 5'd0, 0, 5'd6, 1, 0);
        plen = 2; run_prog();
        chk_int("R3 back-to-back stall cycles", c_stall, 2);

        // R4: one instruction between
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0);
        prog[1] = mk(1, 5'd1, 1, 5'd2, 0, 5'd7, 1, 0);
        prog[2] = mk(1, 5'd0, 0, 5'd5, 1, 5'd8, 1, 0);
        plen = 3; run_prog();
        chk_int("R4 distance-two stall cycles", c_stall, 1);

        // R5: two instructions between
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0);
        prog[1] = mk(1, 5'd1, 1, 5'd2, 0, 5'd7, 1, 0);
        prog[2] = mk(1, 5'd1, 1, 5'd2, 0, 5'd9, 1, 0);
        prog[3] = mk(1, 5'd5, 1, 5'd5, 1, 5'd8, 1, 0);
        plen = 4; run_prog();
        chk_int("R5 distance-three stall cycles", c_stall, 0);

        // R6: register 0
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd0, 1, 0);
        prog[1] = mk(1, 5'd0, 1, 5'd0, 1, 5'd6, 1, 0);
        plen = 2; run_prog();
        chk_int("R6 register zero stall cycles", c_stall, 0);

        // R7: source not read
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0);
        prog[1] = mk(1, 5'd5, 0, 5'd5, 0, 5'd6, 1, 0);
        plen = 2; run_prog();
        chk_int("R7 unread source stall cycles", c_stall, 0);

        // R8: producer without write
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 0, 0);
        prog[1] = mk(1, 5'd5, 1, 5'd5, 1, 5'd6, 1, 0);
        plen = 2; run_prog();
        chk_int("R8 non-writing producer stall cycles", c_stall, 0);

        // R12: invalid decode slot
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 0);
        prog[1] = mk(0, 5'd5, 1, 5'd5, 1, 5'd6, 1, 0);
        plen = 2; run_prog();
        chk_int("R12 invalid decode stall cycles", c_stall, 0);

        // R9: lone memory access
        prog[0] = mk(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 1);
        plen = 1; run_prog();
        chk_int("R9 port conflict cycles", c_port, 1);

        // R11 / R10: dependent memory access behind a load
        prog[0] = mk(1, 5'd1, 1, 5'd2, 0, 5'd5, 1, 1);
        prog[1] = mk(1, 5'd5, 1, 5'd3, 1, 5'd0, 0, 1);
        plen = 2; run_prog();
        chk_int("R11 stall cycles", c_stall, 2);
        chk_int("R11 port cycles", c_port, 2);
        chk_int("R10 overlap cycles", c_both, 1);

        // Random programs
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 16; k++) begin
                prog[k] = mk(($urandom % 8) != 0,
                             5'($urandom % 4), 1'($urandom % 2),
                             5'($urandom % 4), 1'($urandom % 2),
                             5'($urandom % 4), 1'($urandom % 2),
                             ($urandom % 10) < 3);
            end
            plen = 16; run_prog();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule